// File: doc/BRIEF.md
# Serial Channel with Four-Deep Receive Buffer

This block is one full-duplex asynchronous serial channel, meant to be instantiated twice to form a dual-channel serial controller. The transmitter and the receiver each run from their own oversampling clock enable. A baud generator outside the block supplies these enables at sixteen times the bit rate. Bytes written to a one-entry transmit holding register go out as framed characters on `txd`. Frames arriving on `rxd` are checked and stored in a four-entry receive FIFO. Software reads them out through the receive data address.

A two-bit register select gives access to four locations. Address 0 is the mode register (read and write). Address 1 is the command register (write only). Address 2 is the status register (read only). Address 3 is data: a write loads the transmit holding register and a read returns the receive FIFO head. The mode register holds these fields:

- bits [1:0]: character length minus five.
- bits [3:2]: parity type.
- bit 4: the forced parity value.
- bit 5: two stop bits.

The status register, from bit 7 down to bit 0, holds:

- bit 7: received break.
- bit 6: framing error.
- bit 5: parity error.
- bit 4: overrun.
- bit 3: transmitter empty.
- bit 2: transmit ready.
- bit 1: receive FIFO full.
- bit 0: receive ready.

The request-to-send output `rts_out` (high means the remote end may send) drops by itself while the receive FIFO is full.

Top module: `uart_channel`

## Requirements
- R1: A frame is a low start bit, then 5 to 8 data bits (mode bits [1:0] = 0..3) LSB first, then an optional parity bit, then one stop bit, or two when mode bit 5 is 1. Received characters have the bits above the character length read as zero.
- R2: Mode bits [3:2] select the parity type: 00 none, 01 even, 10 odd, 11 forced to the value of mode bit 4. A received parity bit that does not match sets status bit 5, and the character is still stored.
- R3: The receive FIFO holds up to four characters in arrival order. Status bit 0 is 1 while it is non-empty, and status bit 1 is 1 while it is full. A read of address 3 returns the oldest character and removes it.
- R4: A character that completes while the FIFO is full is discarded and sets status bit 4. The four stored characters are returned unchanged.
- R5: If the first stop bit is sampled low, status bit 6 is set. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: A frame whose data, parity and stop bits are all low stores exactly one character 0x00 and sets status bits 7 and 6, however long the line stays low.
- R7: `rts_out` is 0 while the FIFO holds four characters and 1 otherwise.
- R8: Command bits control the two enables: bit 0 enables the transmitter, bit 1 disables it, bit 2 enables the receiver and bit 3 disables it. If the enable and disable bits are both set, disable wins. A disabled receiver ignores start bits. A disabled transmitter clears status bit 2, ignores writes to address 3 and keeps `txd` high.
- R9: Command bit 5 starts a break: `txd` is driven low once any character in progress has finished. Command bit 6 ends the break and returns `txd` high.
- R10: Status bits 7..4 stay set until a command write with bit 4 set clears them.
- R11: A start bit is accepted only if the line is still low at the middle of the start bit. A shorter low pulse stores nothing.
- R12: A write to address 3 is accepted while status bit 2 is 1. One character can wait in the holding register while another is being shifted out. After reset the status reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_tick | input | 1 | Transmit oversampling enable (OSR per bit) |
| rx_tick | input | 1 | Receive oversampling enable (OSR per bit) |
| reg_sel | input | 2 | Register select: 0 mode, 1 command, 2 status, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO when reg_sel is 3) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| rts_out | output | 1 | Request to send: high while the FIFO has room |

## Verification
The bench builds the channel with OSR = 16 and FIFO_DEPTH = 4, and holds both tick inputs high. Each bit therefore lasts exactly sixteen clocks, so the bench can place its samples at mid-bit on the transmit line and drive the receive line with hand-built frames. These frames include bad parity, a low stop bit, a long break and a short glitch. With a depth of four, five back-to-back frames are enough to reach the full-FIFO drop of `rts_out` and the overrun drop of a fifth character. A loopback from `txd` to `rxd` checks that both directions agree on 8-bit and 6-bit framing.

// File: rtl/uart_ch_pkg.sv
package uart_ch_pkg;

  localparam int CHAR_W = 8;
  localparam int FRAME_W = 12;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_FORCE = 2'b11
  } par_mode_e;

  // packed into mode register bits [5:0]
  typedef struct packed {
    logic      stop2;
    logic      force_val;
    par_mode_e par;
    logic [1:0] len;
  } mode_t;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  function automatic logic [3:0] data_bits(input mode_t m);
    return 4'd5 + {2'b00, m.len};
  endfunction

  function automatic logic [CHAR_W-1:0] mask_data(input logic [CHAR_W-1:0] d, input mode_t m);
    return d & ~(8'hFF << data_bits(m));
  endfunction

  function automatic logic parity_of(input logic [CHAR_W-1:0] d, input mode_t m);
    logic [CHAR_W-1:0] dm;
    dm = mask_data(d, m);
    case (m.par)
      PAR_EVEN:  return ^dm;
      PAR_ODD:   return ~^dm;
      PAR_FORCE: return m.force_val;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] frame_len(input mode_t m);
    return 4'd2 + data_bits(m) + {3'b000, m.par != PAR_NONE} + {3'b000, m.stop2};
  endfunction

  // bit 0 goes out first; unused high positions are stop/idle ones
  function automatic logic [FRAME_W-1:0] build_frame(input logic [CHAR_W-1:0] d, input mode_t m);
    logic [FRAME_W-1:0] f;
    logic [3:0] pp;
    pp = data_bits(m) + 4'd1;
    f = ({FRAME_W{1'b1}} << pp) | {3'b000, mask_data(d, m), 1'b0};
    if (m.par != PAR_NONE) begin
      f = (f & ~(12'd1 << pp)) | ({11'd0, parity_of(d, m)} << pp);
    end
    return f;
  endfunction

endpackage

// File: rtl/uart_ch_fifo.sv
module uart_ch_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R4
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R3

endmodule

// File: rtl/uart_ch_tx.sv
module uart_ch_tx
  import uart_ch_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              brk_on,
  input  mode_t             mode,
  input  logic              thr_wr,
  input  logic [CHAR_W-1:0] thr_data,
  output logic              tx_rdy,
  output logic              tx_empty,
  output logic              txd
);
  localparam int CW = $clog2(OSR);

  logic [CHAR_W-1:0]  thr;
  logic               thr_full;
  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [3:0]         left;
  logic [CW-1:0]      cnt;

  // named events for the assertions
  logic load, bit_end;
  assign load    = !busy && thr_full && en && !brk_on;
  assign bit_end = busy && tick && (cnt == CW'(OSR - 1));

  assign tx_rdy   = en && !thr_full;
  assign tx_empty = !thr_full && !busy;
  assign txd      = busy ? shreg[0] : !brk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr      <= '0;
      thr_full <= 1'b0;
      busy     <= 1'b0;
      shreg    <= '1;
      left     <= '0;
      cnt      <= '0;
    end else begin
      if (thr_wr && tx_rdy) begin
        thr      <= thr_data;
        thr_full <= 1'b1;
      end
      if (load) begin
        shreg    <= build_frame(thr, mode);
        left     <= frame_len(mode);
        cnt      <= '0;
        busy     <= 1'b1;
        thr_full <= 1'b0;
      end else if (bit_end) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else if (busy && tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R1
  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left == 4'd1) |-> txd); // R1
  AST_TX_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_rdy) |=> $stable(thr)); // R8
  AST_TX_BREAK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_on && busy) |=> (busy || !txd)); // R9

endmodule

// File: rtl/uart_ch_rx.sv
module uart_ch_rx
  import uart_ch_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  mode_t             mode,
  input  logic              rxd,
  output logic              done,
  output logic [CHAR_W-1:0] data,
  output logic              pe,
  output logic              fe,
  output logic              brk
);
  localparam int CW = $clog2(OSR);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} rx_st_e;

  rx_st_e            st;
  logic              sync1, rx_s;
  logic [CW-1:0]     cnt;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] sh;
  logic              pbit;

  logic mid_pt, bit_end, par_en;
  assign mid_pt  = tick && (cnt == CW'(OSR / 2 - 1));
  assign bit_end = tick && (cnt == CW'(OSR - 1));
  assign par_en  = (mode.par != PAR_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rx_s  <= 1'b1;
      st    <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      pe    <= 1'b0;
      fe    <= 1'b0;
      brk   <= 1'b0;
    end else begin
      sync1 <= rxd;
      rx_s  <= sync1;
      done  <= 1'b0;
      case (st)
        S_IDLE: if (en && tick && !rx_s) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (mid_pt) begin
          cnt <= '0;
          idx <= '0;
          sh  <= '0;
          st  <= rx_s ? S_IDLE : S_DATA;
        end else if (tick) cnt <= cnt + 1'b1;
        S_DATA: if (bit_end) begin
          cnt     <= '0;
          sh[idx] <= rx_s;
          idx     <= idx + 3'd1;
          if (idx == 3'(data_bits(mode) - 4'd1)) st <= par_en ? S_PAR : S_STOP;
        end else if (tick) cnt <= cnt + 1'b1;
        S_PAR: if (bit_end) begin
          cnt  <= '0;
          pbit <= rx_s;
          st   <= S_STOP;
        end else if (tick) cnt <= cnt + 1'b1;
        S_STOP: if (bit_end) begin
          cnt  <= '0;
          done <= 1'b1;
          data <= sh;
          pe   <= par_en && (pbit != parity_of(sh, mode));
          fe   <= !rx_s;
          brk  <= !rx_s && (sh == '0) && (!par_en || !pbit);
          st   <= rx_s ? S_IDLE : S_HOLD;
        end else if (tick) cnt <= cnt + 1'b1;
        S_HOLD: if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RX_BREAK_IS_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (done && brk) |-> (fe && data == '0)); // R6
  AST_RX_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((data & (8'hFF << data_bits(mode))) == '0)); // R1
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_RX_HOLD_AFTER_FE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fe) |-> (st == S_HOLD)); // R5

endmodule

// File: rtl/uart_channel.sv
module uart_channel
  import uart_ch_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_tick,
  input  logic       rx_tick,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       rts_out
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  mode_t mode_q;
  logic  tx_en, rx_en, brk_on;
  logic  err_ovr, err_pe, err_fe, err_brk;

  logic              tx_rdy, tx_empty;
  logic              rx_done, rx_pe, rx_fe, rx_brk;
  logic [CHAR_W-1:0] rx_data, fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_full, fifo_empty;

  // named bus events
  logic cmd_wr, thr_wr, pop, push, overrun_ev, err_clr;
  assign cmd_wr     = reg_wr && (reg_sel == SEL_CMD);
  assign thr_wr     = reg_wr && (reg_sel == SEL_DATA);
  assign pop        = reg_rd && (reg_sel == SEL_DATA) && !fifo_empty;
  assign push       = rx_done && (!fifo_full || pop);
  assign overrun_ev = rx_done && fifo_full && !pop;
  assign err_clr    = cmd_wr && reg_wdata[4];

  assign rts_out = !fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      brk_on  <= 1'b0;
      err_ovr <= 1'b0;
      err_pe  <= 1'b0;
      err_fe  <= 1'b0;
      err_brk <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == SEL_MODE) mode_q <= mode_t'(reg_wdata[5:0]);
      if (cmd_wr) begin
        if (reg_wdata[1]) tx_en <= 1'b0;
        else if (reg_wdata[0]) tx_en <= 1'b1;
        if (reg_wdata[3]) rx_en <= 1'b0;
        else if (reg_wdata[2]) rx_en <= 1'b1;
        if (reg_wdata[6]) brk_on <= 1'b0;
        else if (reg_wdata[5]) brk_on <= 1'b1;
      end
      err_ovr <= (err_ovr && !err_clr) || overrun_ev;
      err_pe  <= (err_pe  && !err_clr) || (rx_done && rx_pe);
      err_fe  <= (err_fe  && !err_clr) || (rx_done && rx_fe);
      err_brk <= (err_brk && !err_clr) || (rx_done && rx_brk);
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_MODE: reg_rdata = {2'b00, mode_q};
      SEL_STAT: reg_rdata = {err_brk, err_fe, err_pe, err_ovr,
                             tx_empty, tx_rdy, fifo_full, !fifo_empty};
      SEL_DATA: reg_rdata = fifo_dout;
      default:  reg_rdata = 8'h00;
    endcase
  end

  uart_ch_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .en(tx_en), .brk_on(brk_on),
    .mode(mode_q), .thr_wr(thr_wr), .thr_data(reg_wdata),
    .tx_rdy(tx_rdy), .tx_empty(tx_empty), .txd(txd)
  );

  uart_ch_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .en(rx_en), .mode(mode_q),
    .rxd(rxd), .done(rx_done), .data(rx_data),
    .pe(rx_pe), .fe(rx_fe), .brk(rx_brk)
  );

  uart_ch_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(rx_data),
    .dout(fifo_dout), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  AST_RTS_DROPS_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && fifo_cnt == CNT_W'(FIFO_DEPTH - 1)) |=> !rts_out); // R7
  AST_OVERRUN_KEEPS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> (fifo_cnt == $past(fifo_cnt)) && err_ovr); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_ovr || err_pe || err_fe || err_brk) && !err_clr)
      |=> (err_ovr || err_pe || err_fe || err_brk)); // R10
  AST_POP_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fifo_cnt != '0)); // R3

endmodule

// File: tb/tb_uart_channel.sv
module tb_uart_channel;
  localparam int OSR   = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       txd, rxd, rts_out;
  logic       loop = 1'b0, drv_rxd = 1'b1;

  assign rxd = loop ? txd : drv_rxd;

  uart_channel #(.OSR(OSR), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .tx_tick(1'b1), .rx_tick(1'b1),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .txd(txd), .rxd(rxd), .rts_out(rts_out)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); reg_sel = 2'd3; #1 d = reg_rdata; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [7:0] mk_mode(input int nb, input int par, input bit fv, input bit two);
    return 8'((two ? 32 : 0) + (fv ? 16 : 0) + par * 4 + (nb - 5));
  endfunction

  // frame bits in line order, own construction
  function automatic logic [11:0] mk_frame(input logic [7:0] d, input int nb, input int par,
                                           input bit fv, input bit two, output int len);
    logic [11:0] f = '1;
    int p = 0, ones = 0;
    f[p] = 1'b0; p++;
    for (int i = 0; i < nb; i++) begin f[p] = d[i]; ones += d[i]; p++; end
    if (par != 0) begin
      f[p] = (par == 1) ? logic'(ones % 2) : (par == 2) ? logic'(1 - ones % 2) : fv;
      p++;
    end
    p += two ? 2 : 1;
    len = p;
    return f;
  endfunction

  task automatic send_frame(input logic [11:0] f, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); drv_rxd = f[i];
      repeat (OSR - 1) @(negedge clk);
    end
    @(negedge clk); drv_rxd = 1'b1;
    repeat (2 * OSR) @(negedge clk);
  endtask

  task automatic capture_tx(input int len, output logic [11:0] bits);
    int t = 0;
    bits = '1;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    repeat (OSR / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      bits[i] = txd;
      repeat (OSR) @(negedge clk);
    end
  endtask

  task automatic drain(input string tag);
    logic [7:0] st, d;
    rd(2'd2, st);
    while (st[0]) begin
      pop(d);
      if (exp_q.size() == 0) check({tag, " extra char"}, d, 32'hFFFF);
      else check(tag, d, exp_q.pop_front());
      rd(2'd2, st);
    end
    check({tag, " all expected chars seen"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  st, d;
    logic [11:0] f, cap;
    int len, lows;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(2'd2, st);
    check("R12 reset status", st, 8'h08);
    check("R7 reset rts", rts_out, 1);
    check("R9 reset txd idle", txd, 1);

    // R1 loopback 8N1, two writes back to back (R12 holding register)
    wr(2'd0, mk_mode(8, 0, 0, 0));
    wr(2'd1, 8'h05);
    rd(2'd2, st);
    check("R12 tx ready after enable", st, 8'h0C);
    loop = 1'b1;
    wr(2'd3, 8'hA5); exp_q.push_back(8'hA5);
    rd(2'd2, st);
    check("R12 holding free while shifting", st[2], 1);
    wr(2'd3, 8'h3C); exp_q.push_back(8'h3C);
    repeat (400) @(negedge clk);
    drain("R1 loopback 8N1");

    // R1 R2 loopback 6 bits odd parity 2 stop, upper bits masked
    wr(2'd0, mk_mode(6, 2, 0, 1));
    wr(2'd3, 8'hFF); exp_q.push_back(8'h3F);
    repeat (250) @(negedge clk);
    drain("R1 loopback 6O2 masked");
    rd(2'd2, st);
    check("R2 no parity error on loopback", st[5], 0);
    loop = 1'b0;

    // R1 R2 direct frame: 7 bits even parity 2 stop
    wr(2'd0, mk_mode(7, 1, 0, 1));
    wr(2'd3, 8'h35);
    f = mk_frame(8'h35, 7, 1, 0, 1, len);
    capture_tx(len, cap);
    check("R2 7E2 frame on txd", cap & ~(12'hFFF << len), f & ~(12'hFFF << len));
    // R2 forced parity 1, 5 bits
    wr(2'd0, mk_mode(5, 3, 1, 0));
    wr(2'd3, 8'h1A);
    f = mk_frame(8'h1A, 5, 3, 1, 0, len);
    capture_tx(len, cap);
    check("R2 5-bit forced-1 frame on txd", cap & ~(12'hFFF << len), f & ~(12'hFFF << len));
    repeat (40) @(negedge clk);
    rd(2'd2, st);
    check("R12 tx empty after frame", st[3], 1);

    // R2 parity error: odd mode, frame built with even parity
    wr(2'd0, mk_mode(8, 2, 0, 0));
    f = mk_frame(8'h5A, 8, 1, 0, 0, len);
    send_frame(f, len); exp_q.push_back(8'h5A);
    rd(2'd2, st);
    check("R2 parity error flagged", st[5], 1);
    f = mk_frame(8'h11, 8, 2, 0, 0, len);
    send_frame(f, len); exp_q.push_back(8'h11);
    rd(2'd2, st);
    check("R10 parity error sticky over good frame", st[5], 1);
    drain("R2 chars kept despite parity error");
    wr(2'd1, 8'h10);
    rd(2'd2, st);
    check("R10 reset-error command clears", st[7:4], 4'h0);

    // R5 framing error
    wr(2'd0, mk_mode(8, 0, 0, 0));
    f = mk_frame(8'h55, 8, 0, 0, 0, len);
    f[len-1] = 1'b0;
    send_frame(f, len); exp_q.push_back(8'h55);
    rd(2'd2, st);
    check("R5 framing error flagged", st[7:6], 2'b01);
    drain("R5 char with framing error");
    wr(2'd1, 8'h10);

    // R6 long break, one char
    @(negedge clk); drv_rxd = 1'b0;
    repeat (30 * OSR) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (3 * OSR) @(negedge clk);
    exp_q.push_back(8'h00);
    rd(2'd2, st);
    check("R6 break and framing flags", st[7:6], 2'b11);
    drain("R6 single break char");
    wr(2'd1, 8'h10);

    // R3 R4 R7 fill, overrun
    for (int k = 1; k <= 5; k++) begin
      f = mk_frame(8'(k * 17), 8, 0, 0, 0, len);
      send_frame(f, len);
      if (k <= 4) exp_q.push_back(8'(k * 17));
      if (k == 3) check("R7 rts high with three stored", rts_out, 1);
      if (k == 4) begin
        check("R7 rts low when full", rts_out, 0);
        rd(2'd2, st);
        check("R3 full and ready flags", st[1:0], 2'b11);
        check("R4 no overrun yet", st[4], 0);
      end
    end
    rd(2'd2, st);
    check("R4 overrun flagged", st[4], 1);
    drain("R3 R4 order and preserved chars");
    check("R7 rts high after drain", rts_out, 1);
    wr(2'd1, 8'h10);

    // R11 short glitch ignored
    @(negedge clk); drv_rxd = 1'b0;
    repeat (4) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (3 * OSR) @(negedge clk);
    rd(2'd2, st);
    check("R11 glitch stores nothing", st[0], 0);

    // R8 receiver disabled
    wr(2'd1, 8'h08);
    f = mk_frame(8'h77, 8, 0, 0, 0, len);
    send_frame(f, len);
    rd(2'd2, st);
    check("R8 disabled receiver ignores frame", st[0], 0);
    wr(2'd1, 8'h04);

    // R8 transmitter disabled, write ignored
    wr(2'd1, 8'h02);
    rd(2'd2, st);
    check("R8 tx ready low when disabled", st[2], 0);
    wr(2'd3, 8'h12);
    lows = 0;
    for (int i = 0; i < 250; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    check("R8 disabled tx line high", lows, 0);
    rd(2'd2, st);
    check("R8 write ignored, tx empty", st[3], 1);
    wr(2'd1, 8'h01);
    lows = 0;
    for (int i = 0; i < 250; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    check("R8 nothing queued after re-enable", lows, 0);

    // R9 break waits for current char
    wr(2'd3, 8'hC3);
    wr(2'd1, 8'h20);
    f = mk_frame(8'hC3, 8, 0, 0, 0, len);
    capture_tx(len, cap);
    check("R9 char finishes before break", cap & ~(12'hFFF << len), f & ~(12'hFFF << len));
    repeat (40) @(negedge clk);
    check("R9 break drives low", txd, 0);
    repeat (200) @(negedge clk);
    check("R9 break held low", txd, 0);
    wr(2'd1, 8'h40);
    @(negedge clk);
    check("R9 stop break returns high", txd, 1);

    summary();
    $finish;
  end

endmodule